// File: doc/BRIEF.md
# Priority Memory Chip-Select Decoder

This block turns a processor address into a single chip select out of seven windows. Four of them cover blocks of code memory. One covers a small scratch RAM, one covers on-chip I/O registers and one covers a region for external peripherals. Each window has a base, a power-of-two size and an enable. These are held in registers and loaded through a narrow configuration write port. The decode from address to select is purely combinational, so a select follows the address within the same cycle.

Some overlaps are allowed. The RAM and I/O windows may sit on top of code space. In that case they win, and the code bytes beneath them cannot be reached. Other overlaps are not allowed: two code windows, or two of the RAM/I/O windows, covering the same bytes. Those overlaps, an oversized window and a base that is not aligned to its window size all set a sticky configuration error. That check runs on the cycle after every window write. The error bit stays set until a dedicated clear write.

Top module: `csel_decoder`

## Requirements
- R1: After reset, every window is disabled, no select is asserted, `hitNone` is 1 and `cfgErr` is 0.
- R2: A write with `cfgWe`=1 loads the window picked by `cfgSel`: 0 to 3 are code windows 0 to 3, 4 is the scratch RAM, 5 is on-chip I/O and 6 is the peripheral region. The window takes its base from `cfgBase`, its size as log2 bytes from `cfgSize`, and `cfgEn`. `cfgEn`=0 disables the window.
- R3: An enabled window whose base is aligned covers the bytes from base to base + 2^size - 1. Its select is asserted, in the same cycle, for every address in that range and for no address outside it. The select vector is {hitNone, pioSel, iioSel, sramSel, codeSel[3:0]}.
- R4: At most one select is asserted for any address. `hitNone` is 1 exactly when no select is asserted. Among overlapping code windows, the lowest index wins.
- R5: When the RAM or an I/O window overlaps a code window, the RAM or I/O select is asserted and the code select is not. The fixed order is RAM, then on-chip I/O, then peripheral.
- R6: The peripheral select can be asserted only while `pioMode`=1. While `pioMode`=0, the peripheral window is ignored, and its addresses fall through to code windows or to no hit.
- R7: A window larger than its limit sets `cfgErr`. The limits are 2^13 bytes for a code window, 2^11 for the RAM and 2^8 for either I/O window.
- R8: An enabled window whose base has any bit set below bit `size` sets `cfgErr`.
- R9: An overlap between two enabled code windows, or between two enabled RAM/I/O windows, sets `cfgErr`. An overlap between a RAM/I/O window and a code window does not.
- R10: `cfgErr` reads 1 from the second clock edge after the faulty window write. It stays 1 through later writes until a write with `cfgSel`=7, which clears it at that edge. Reset also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Window index 0..6, or 7 to clear the error |
| cfgBase | input | 16 | Window base address |
| cfgSize | input | 5 | Window size as log2 bytes |
| cfgEn | input | 1 | Window enable |
| pioMode | input | 1 | Peripheral region active |
| addr | input | 16 | Address to decode |
| codeSel | output | 4 | Code block selects |
| sramSel | output | 1 | Scratch RAM select |
| iioSel | output | 1 | On-chip I/O select |
| pioSel | output | 1 | Peripheral region select |
| hitNone | output | 1 | No window matched |
| cfgErr | output | 1 | Sticky configuration error |

## Verification
The assertions assume the following about the inputs:
- `cfgSel` and `cfgWe` are steady at the clock edge.
- A clear write does not land on the cycle right after a faulty window write. If it did, the clear and the new error would meet at one edge.

The bench drives every input one time unit after a rising edge. It always leaves an idle cycle after each window write before it issues a clear. This keeps the check strobe and the clear strobe apart, so the stickiness and clear assertions see clean sequences.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  localparam int NUM_CODE = 4;
  localparam int NUM_REG  = NUM_CODE + 3;
  localparam int REG_SRAM = NUM_CODE;
  localparam int REG_IIO  = NUM_CODE + 1;
  localparam int REG_PIO  = NUM_CODE + 2;
  localparam int SEL_W    = $clog2(NUM_REG + 1);
  localparam int SEL_CLR  = NUM_REG;

  typedef struct packed {
    logic [NUM_REG-1:0] load;
    logic               clrErr;
    logic               check;
  } cselStrobe_t;
endpackage

// File: rtl/csel_ctrl.sv
`timescale 1ns/1ps
module csel_ctrl
  import csel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  output cselStrobe_t      strobe
);
  logic checkQ;
  logic winWrite;

  assign winWrite = cfgWe && (cfgSel < SEL_W'(NUM_REG));

  // check the new configuration one cycle after it lands
  always_ff @(posedge clk) begin
    if (!rstN) checkQ <= 1'b0;
    else       checkQ <= winWrite;
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_REG; i++)
      strobe.load[i] = cfgWe && (cfgSel == SEL_W'(i));
    strobe.clrErr = cfgWe && (cfgSel == SEL_W'(SEL_CLR));
    strobe.check  = checkQ;
  end
endmodule

// File: rtl/csel_datapath.sv
`timescale 1ns/1ps
module csel_datapath
  import csel_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SZ_W          = 5,
  parameter int CODE_MAX_LOG2 = 13,
  parameter int SRAM_MAX_LOG2 = 11,
  parameter int IO_MAX_LOG2   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  cselStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [SZ_W-1:0]     cfgSize,
  input  logic                cfgEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                pioMode,
  output logic [NUM_CODE-1:0] codeSel,
  output logic                sramSel,
  output logic                iioSel,
  output logic                pioSel,
  output logic                hitNone,
  output logic                cfgErr
);
  logic [ADDR_W-1:0]  baseQ [NUM_REG];
  logic [SZ_W-1:0]    sizeQ [NUM_REG];
  logic [NUM_REG-1:0] enQ;
  logic [NUM_REG-1:0] hit, misalign, tooBig;
  logic               clash, violation, errQ;

  function automatic logic [ADDR_W-1:0] lowMask(input logic [SZ_W-1:0] s);
    if (32'(s) >= ADDR_W) return '1;
    return (ADDR_W'(1) << s) - ADDR_W'(1);
  endfunction

  function automatic logic overlaps(input logic [ADDR_W-1:0] ba, input logic [SZ_W-1:0] sa,
                                    input logic [ADDR_W-1:0] bb, input logic [SZ_W-1:0] sb);
    logic [SZ_W-1:0] m;
    m = (sa > sb) ? sa : sb;
    return ((ba ^ bb) & ~lowMask(m)) == '0;
  endfunction

  for (genvar g = 0; g < NUM_REG; g++) begin : gWin
    localparam int LIM = (g < NUM_CODE) ? CODE_MAX_LOG2 :
                         (g == REG_SRAM) ? SRAM_MAX_LOG2 : IO_MAX_LOG2;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g] <= '0;
        sizeQ[g] <= '0;
        enQ[g]   <= 1'b0;
      end else if (strobe.load[g]) begin
        baseQ[g] <= cfgBase;
        sizeQ[g] <= cfgSize;
        enQ[g]   <= cfgEn;
      end
    end
    assign hit[g]      = enQ[g] && (((addr ^ baseQ[g]) & ~lowMask(sizeQ[g])) == '0);
    assign misalign[g] = enQ[g] && ((baseQ[g] & lowMask(sizeQ[g])) != '0);
    assign tooBig[g]   = enQ[g] && (sizeQ[g] > SZ_W'(LIM));
  end

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NUM_CODE; i++)
      for (int j = i + 1; j < NUM_CODE; j++)
        if (enQ[i] && enQ[j] && overlaps(baseQ[i], sizeQ[i], baseQ[j], sizeQ[j])) clash = 1'b1;
    for (int i = NUM_CODE; i < NUM_REG; i++)
      for (int j = i + 1; j < NUM_REG; j++)
        if (enQ[i] && enQ[j] && overlaps(baseQ[i], sizeQ[i], baseQ[j], sizeQ[j])) clash = 1'b1;
  end

  assign violation = clash || (|misalign) || (|tooBig);

  always_ff @(posedge clk) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= (errQ && !strobe.clrErr) || (strobe.check && violation);
  end
  assign cfgErr = errQ;

  always_comb begin
    logic found;
    codeSel = '0;
    sramSel = 1'b0;
    iioSel  = 1'b0;
    pioSel  = 1'b0;
    found   = 1'b0;
    if (hit[REG_SRAM])                sramSel = 1'b1;
    else if (hit[REG_IIO])            iioSel  = 1'b1;
    else if (hit[REG_PIO] && pioMode) pioSel  = 1'b1;
    else begin
      for (int i = 0; i < NUM_CODE; i++)
        if (hit[i] && !found) begin
          codeSel[i] = 1'b1;
          found      = 1'b1;
        end
    end
  end

  assign hitNone = !(sramSel || iioSel || pioSel || (|codeSel));
endmodule

// File: rtl/csel_decoder.sv
`timescale 1ns/1ps
module csel_decoder
  import csel_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SZ_W          = 5,
  parameter int CODE_MAX_LOG2 = 13,
  parameter int SRAM_MAX_LOG2 = 11,
  parameter int IO_MAX_LOG2   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [ADDR_W-1:0]   cfgBase,
  input  logic [SZ_W-1:0]     cfgSize,
  input  logic                cfgEn,
  input  logic                pioMode,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CODE-1:0] codeSel,
  output logic                sramSel,
  output logic                iioSel,
  output logic                pioSel,
  output logic                hitNone,
  output logic                cfgErr
);
  cselStrobe_t strobe;

  csel_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .strobe(strobe)
  );

  csel_datapath #(
    .ADDR_W(ADDR_W), .SZ_W(SZ_W), .CODE_MAX_LOG2(CODE_MAX_LOG2),
    .SRAM_MAX_LOG2(SRAM_MAX_LOG2), .IO_MAX_LOG2(IO_MAX_LOG2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgBase(cfgBase), .cfgSize(cfgSize),
    .cfgEn(cfgEn), .addr(addr), .pioMode(pioMode), .codeSel(codeSel),
    .sramSel(sramSel), .iioSel(iioSel), .pioSel(pioSel), .hitNone(hitNone),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/csel_decoder_chk.sv
`timescale 1ns/1ps
module csel_decoder_chk
  import csel_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cfgWe,
  input logic [SEL_W-1:0]    cfgSel,
  input logic                pioMode,
  input logic [NUM_CODE-1:0] codeSel,
  input logic                sramSel,
  input logic                iioSel,
  input logic                pioSel,
  input logic                hitNone,
  input logic                cfgErr
);
  a_r4_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({codeSel, sramSel, iioSel, pioSel}));

  a_r4_hit_none: assert property (@(posedge clk) disable iff (!rstN)
    hitNone == ({codeSel, sramSel, iioSel, pioSel} == '0));

  a_r6_pio_mode: assert property (@(posedge clk) disable iff (!rstN)
    pioSel |-> pioMode);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !(cfgWe && cfgSel == SEL_W'(SEL_CLR))) |=> cfgErr);

  a_r10_set_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> ($past(cfgWe, 2) && $past(cfgSel, 2) != SEL_W'(SEL_CLR)));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == SEL_W'(SEL_CLR) && !$past(cfgWe)) |=> !cfgErr);
endmodule

bind csel_decoder csel_decoder_chk i_chk (.*);

// File: tb/test_csel_decoder.sv
`timescale 1ns/1ps
module test_csel_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgBase = '0;
  logic [4:0]  cfgSize = '0;
  logic        cfgEn = 1'b0;
  logic        pioMode = 1'b0;
  logic [15:0] addr = '0;
  logic [3:0]  codeSel;
  logic        sramSel, iioSel, pioSel, hitNone, cfgErr;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  csel_decoder i_csel_decoder (.*);

  function automatic logic [7:0] selVec();
    return {hitNone, pioSel, iioSel, sramSel, codeSel};
  endfunction

  task automatic expectSel(input logic [15:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.a = a; it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: compares at the falling edge following each drive
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        tests++;
        if (selVec() !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.a, selVec(), it.exp);
        end
      end
    end
  end

  task automatic checkErr(input logic exp, input string tag);
    @(negedge clk);
    tests++;
    if (cfgErr !== exp) begin
      fails++;
      $display("FAIL %s cfgErr actual=%b expected=%b", tag, cfgErr, exp);
    end
  endtask

  // write, then one idle edge so the check strobe has acted
  task automatic cfgWrite(input logic [2:0] s, input logic [15:0] b, input logic [4:0] z, input logic e);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = s; cfgBase = b; cfgSize = z; cfgEn = e;
    @(posedge clk); #1;
    cfgWe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic clearErr();
    cfgWrite(3'd7, 16'h0, 5'd0, 1'b0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expectSel(16'h0000, 8'h80, "R1 no window after reset");
    checkErr(1'b0, "R1 error clear after reset");

    // R2 legal map: code0 0000/8K, code1 2000/8K, code2 4000/4K, code3 8000/8K
    cfgWrite(3'd0, 16'h0000, 5'd13, 1'b1);
    cfgWrite(3'd1, 16'h2000, 5'd13, 1'b1);
    cfgWrite(3'd2, 16'h4000, 5'd12, 1'b1);
    cfgWrite(3'd3, 16'h8000, 5'd13, 1'b1);
    cfgWrite(3'd4, 16'h2000, 5'd11, 1'b1);
    cfgWrite(3'd5, 16'h4000, 5'd8, 1'b1);
    cfgWrite(3'd6, 16'h9000, 5'd8, 1'b1);
    checkErr(1'b0, "R9 legal shadowing raises no error");

    expectSel(16'h0010, 8'h01, "R3 code0 hit");
    expectSel(16'h3FFF, 8'h02, "R3 code1 top byte");
    expectSel(16'h2800, 8'h02, "R3 code1 above ram");
    expectSel(16'h4FFF, 8'h04, "R3 code2 top byte");
    expectSel(16'h5000, 8'h80, "R3 past code2 end");
    expectSel(16'hC000, 8'h80, "R4 unmapped gives hitNone");
    expectSel(16'h2010, 8'h10, "R5 ram shadows code1");
    expectSel(16'h20FF, 8'h10, "R5 ram shadows code1 again");
    expectSel(16'h4010, 8'h20, "R5 io shadows code2");
    expectSel(16'h9010, 8'h08, "R6 pio ignored when mode off");
    @(posedge clk); #1 pioMode = 1'b1;
    expectSel(16'h9010, 8'h40, "R6 pio wins when mode on");
    expectSel(16'h9100, 8'h08, "R6 past pio end back to code3");

    // R7 oversized code window
    cfgWrite(3'd0, 16'h0000, 5'd14, 1'b1);
    checkErr(1'b1, "R7 oversized code window");
    cfgWrite(3'd0, 16'h0000, 5'd13, 1'b1);
    checkErr(1'b1, "R10 error sticky after fix");
    clearErr();
    checkErr(1'b0, "R10 clear write");

    // R7 oversized ram window
    cfgWrite(3'd4, 16'h2000, 5'd12, 1'b1);
    checkErr(1'b1, "R7 oversized ram window");
    cfgWrite(3'd4, 16'h2000, 5'd11, 1'b1);
    clearErr();
    checkErr(1'b0, "R10 clear after ram fix");

    // R8 misaligned base
    cfgWrite(3'd1, 16'h2100, 5'd13, 1'b1);
    checkErr(1'b1, "R8 misaligned base");
    cfgWrite(3'd1, 16'h2000, 5'd13, 1'b1);
    clearErr();

    // R9 code overlap, lower index wins decode
    cfgWrite(3'd3, 16'h0000, 5'd13, 1'b1);
    checkErr(1'b1, "R9 code windows overlap");
    expectSel(16'h0010, 8'h01, "R4 lowest code index wins");
    cfgWrite(3'd3, 16'h8000, 5'd13, 1'b1);
    clearErr();
    checkErr(1'b0, "R10 clear after code fix");

    // R9 io overlaps ram
    cfgWrite(3'd5, 16'h2000, 5'd8, 1'b1);
    checkErr(1'b1, "R9 ram and io overlap");
    expectSel(16'h2010, 8'h10, "R5 ram beats io");
    cfgWrite(3'd5, 16'h4000, 5'd8, 1'b1);
    clearErr();

    // R2 disable ram window
    cfgWrite(3'd4, 16'h2000, 5'd11, 1'b0);
    expectSel(16'h2010, 8'h02, "R2 disabled ram falls to code1");
    checkErr(1'b0, "R2 disable raises no error");

    // R1 reset again
    @(posedge clk); #1 rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    expectSel(16'h0010, 8'h80, "R1 reset clears windows");

    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule